// File: doc/BRIEF.md
# Maskable Interrupt Aggregator

This block gathers a set of interrupt request lines into a single interrupt output. Each line passes through its own input gate, and a per-line trigger choice makes it respond to a rising edge or to a high level. Events are captured in sticky flags that software clears by writing ones. A separate per-line routing bit decides whether a captured flag drives the shared output. The output can be a level, high while any routed flag is set, or a one-cycle pulse for each routed flag that newly sets.

Software reaches the configuration through a small word-indexed register bus. Writes complete at the clock edge of the write cycle, and reads are combinational. A read issued after any write therefore returns state that already includes that write. This allows a read of the routing register to act as a barrier for earlier writes. The output of one instance may be wired to one input line of another instance to build a two-level tree.

Top module: `intr_aggregator`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0 and `irq_out` is 0.
- R2: Word index 0 is the input gate, 1 the trigger select, 2 the flags (read only, writes ignored), 3 the routing enables, 4 the flag clear (write only, reads 0) and 5 the signalling mode (bit 0 only). Indices 6 and 7 read 0. A write is visible to a read in the next cycle.
- R3: A line whose gate bit is 0 never sets its flag. With the gate bit at 1, events reach the flag.
- R4: With its trigger bit at 1, a line sets its flag on a 0-to-1 change of the input. An input that stays high does not set the flag again after a clear.
- R5: With its trigger bit at 0, a line sets its flag in every cycle that its gated input is high, so a clear only holds once the input is low.
- R6: Writing the clear word clears exactly the flags whose bits are 1. Other flags keep their value.
- R7: When a clear and a new event on the same line fall in the same cycle, the flag stays set.
- R8: The routing bits affect only the output. Flags are captured whatever the routing value.
- R9: In level mode (mode bit 0 = 0), `irq_out` is high exactly while some flag and its routing bit are both 1.
- R10: In pulse mode (mode bit 0 = 1), `irq_out` is high for one cycle after a routed flag newly becomes set. It stays low while routed flags remain set.
- R11: The line count `NCH` is a parameter of at most `DW`. Register bits at or above `NCH` read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational, 0 when no read |
| irq_in | input | NCH | Interrupt request lines |
| irq_out | output | 1 | Aggregated interrupt output |

## Verification
On every cycle the assertions check four things. A flag only rises after a captured event and only falls after a clear bit. An event is never lost to a same-cycle clear. The output in level mode tracks the routed flags, and a pulse never appears without a routed flag. Only the bench scenarios can show the rest: the register map and its read-only and write-only words, edge against level trigger after a clear, gating, and the one-cycle width of pulses. The bench covers these with a behavioural model compared every clock, using a reduced line count so that the unused upper bits are exercised.

// File: rtl/intr_pkg.sv
// Shared definitions for the interrupt aggregator.
// Assumes a 3-bit word index on the register bus.
package intr_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        IDX_GATE  = 3'd0,
        IDX_TRIG  = 3'd1,
        IDX_FLAGS = 3'd2,
        IDX_ROUTE = 3'd3,
        IDX_ACK   = 3'd4,
        IDX_MODE  = 3'd5
    } reg_idx_e;
endpackage

// File: rtl/intr_cfg_regs.sv
// Configuration registers: gate, trigger select, routing and signalling mode.
// Also decodes the write-one-to-clear strobe. Assumes one access per cycle
// and a synchronous active-low reset.
module intr_cfg_regs
    import intr_pkg::*;
#(
    parameter int NCH = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NCH-1:0]       wdata,
    output logic [NCH-1:0]       gate_q,
    output logic [NCH-1:0]       trig_q,
    output logic [NCH-1:0]       route_q,
    output logic                 pulse_mode_q,
    output logic [NCH-1:0]       ack
);
    // Store configuration words on a write to their index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q       <= '0;
            trig_q       <= '0;
            route_q      <= '0;
            pulse_mode_q <= 1'b0;
        end else if (wr_en) begin
            case (addr)
                IDX_GATE:  gate_q       <= wdata;
                IDX_TRIG:  trig_q       <= wdata;
                IDX_ROUTE: route_q      <= wdata;
                IDX_MODE:  pulse_mode_q <= wdata[0];
                default: ;
            endcase
        end
    end

    // Clear strobe: one cycle, only the bits written as one.
    always_comb begin
        ack = (wr_en && addr == IDX_ACK) ? wdata : '0;
    end
endmodule

// File: rtl/intr_capture.sv
// Per-line event detection and sticky flags. Each line is gated, then
// detected as rising edge (trigger 1) or level (trigger 0). A new event
// beats a clear in the same cycle. Assumes inputs synchronous to clk.
module intr_capture #(
    parameter int NCH = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] irq_in,
    input  logic [NCH-1:0] gate,
    input  logic [NCH-1:0] trig,
    input  logic [NCH-1:0] ack,
    output logic [NCH-1:0] flags_q,
    output logic [NCH-1:0] evt
);
    logic [NCH-1:0] in_d;

    for (genvar c = 0; c < NCH; c++) begin : g_line
        logic rise;
        // Rising-edge term from the previous input sample.
        always_comb rise = irq_in[c] & ~in_d[c];
        // Event after gating and trigger selection.
        always_comb evt[c] = gate[c] & (trig[c] ? rise : irq_in[c]);

        // Sticky flag: set on event, cleared by ack unless an event arrives.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags_q[c] <= 1'b0;
                in_d[c]    <= 1'b0;
            end else begin
                flags_q[c] <= (flags_q[c] & ~ack[c]) | evt[c];
                in_d[c]    <= irq_in[c];
            end
        end
    end
endmodule

// File: rtl/intr_signal.sv
// Output stage: level (any routed flag) or one-cycle pulse on each routed
// flag that newly sets. Assumes flags and routing come from registers.
module intr_signal #(
    parameter int NCH = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] flags,
    input  logic [NCH-1:0] route,
    input  logic           pulse_mode,
    output logic           irq_out
);
    logic [NCH-1:0] pend;
    logic [NCH-1:0] pend_d;

    // Routed flags.
    always_comb pend = flags & route;

    // Remember last cycle's routed flags to find new ones.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_d <= '0;
        else        pend_d <= pend;
    end

    // Select level or pulse signalling.
    always_comb irq_out = pulse_mode ? |(pend & ~pend_d) : |pend;
endmodule

// File: rtl/intr_aggregator.sv
// Top of the interrupt aggregator: register bus, read mux, capture and
// output stages. Assumes NCH <= DW; bits at or above NCH read as zero.
module intr_aggregator
    import intr_pkg::*;
#(
    parameter int DW  = 32,
    parameter int NCH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [NCH-1:0]    irq_in,
    output logic              irq_out
);
    logic           wr_en;
    logic [NCH-1:0] gate_q, trig_q, route_q, ack, flags_q, evt;
    logic           pulse_mode_q;

    // Write qualifier.
    always_comb wr_en = bus_sel & bus_wr;

    intr_cfg_regs #(.NCH(NCH)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(bus_addr),
        .wdata(bus_wdata[NCH-1:0]), .gate_q(gate_q), .trig_q(trig_q),
        .route_q(route_q), .pulse_mode_q(pulse_mode_q), .ack(ack)
    );

    intr_capture #(.NCH(NCH)) u_cap (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .gate(gate_q),
        .trig(trig_q), .ack(ack), .flags_q(flags_q), .evt(evt)
    );

    intr_signal #(.NCH(NCH)) u_sig (
        .clk(clk), .rst_n(rst_n), .flags(flags_q), .route(route_q),
        .pulse_mode(pulse_mode_q), .irq_out(irq_out)
    );

    // Combinational read mux, zero-extended to the bus width.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                IDX_GATE:  bus_rdata[NCH-1:0] = gate_q;
                IDX_TRIG:  bus_rdata[NCH-1:0] = trig_q;
                IDX_FLAGS: bus_rdata[NCH-1:0] = flags_q;
                IDX_ROUTE: bus_rdata[NCH-1:0] = route_q;
                IDX_MODE:  bus_rdata[0]       = pulse_mode_q;
                default:   bus_rdata          = '0;
            endcase
        end
    end
endmodule

// File: rtl/intr_aggregator_chk.sv
// Checker for the interrupt aggregator, bound to the top module.
// Assumes synchronous active-low reset; properties are idle while in reset.
module intr_aggregator_chk #(
    parameter int NCH = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           irq_out,
    input logic [NCH-1:0] flags,
    input logic [NCH-1:0] route,
    input logic           pulse_mode,
    input logic [NCH-1:0] ack,
    input logic [NCH-1:0] evt
);
    // A flag only rises after an event was seen (R3, R8).
    assert_flag_needs_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((flags & ~$past(flags) & ~$past(evt)) == '0));

    // A flag only falls where a clear bit was written (R6).
    assert_flag_fall_needs_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((~flags & $past(flags) & ~$past(ack)) == '0));

    // An event is never lost, even with a same-cycle clear (R7).
    assert_event_beats_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(evt) & ~flags) == '0));

    // Level mode output follows routed flags (R9).
    assert_level_output_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse_mode |-> (irq_out == |(flags & route)));

    // A pulse needs a routed flag behind it (R10).
    assert_pulse_has_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_mode && irq_out) |-> (|(flags & route)));
endmodule

bind intr_aggregator intr_aggregator_chk #(.NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_out(irq_out), .flags(flags_q),
    .route(route_q), .pulse_mode(pulse_mode_q), .ack(ack), .evt(evt)
);

// File: tb/intr_aggregator_tb.sv
module intr_aggregator_tb;
    localparam int DW  = 32;
    localparam int NCH = 20;
    localparam logic [31:0] CHM = 32'h000F_FFFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0]    bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [NCH-1:0] irq_in = '0;
    logic          irq_out;

    int checks = 0, errors = 0;
    string cur = "R1";
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    intr_aggregator #(.DW(DW), .NCH(NCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .irq_out(irq_out)
    );

    // Behavioural reference state.
    logic [31:0] m_gate, m_trig, m_route, m_flags, m_last_in, m_last_pend;
    logic        m_mode;

    always @(posedge clk) begin
        logic [31:0] in32, clr, ev;
        in32 = 32'(irq_in);
        if (!rst_n) begin
            m_gate <= 0; m_trig <= 0; m_route <= 0; m_flags <= 0;
            m_last_in <= 0; m_last_pend <= 0; m_mode <= 0;
        end else begin
            clr = 0;
            if (bus_sel && bus_wr) begin
                if (bus_addr == 3'd0) m_gate  <= bus_wdata & CHM;
                if (bus_addr == 3'd1) m_trig  <= bus_wdata & CHM;
                if (bus_addr == 3'd3) m_route <= bus_wdata & CHM;
                if (bus_addr == 3'd5) m_mode  <= bus_wdata[0];
                if (bus_addr == 3'd4) clr = bus_wdata;
            end
            ev = 0;
            for (int i = 0; i < NCH; i++)
                if (m_gate[i] && (m_trig[i] ? (in32[i] && !m_last_in[i]) : in32[i]))
                    ev[i] = 1'b1;
            m_flags     <= ((m_flags & ~clr) | ev) & CHM;
            m_last_in   <= in32;
            m_last_pend <= m_flags & m_route;
        end
    end

    function automatic logic [31:0] exp_rd();
        if (!bus_sel || bus_wr) return 0;
        case (bus_addr)
            3'd0: return m_gate;
            3'd1: return m_trig;
            3'd2: return m_flags;
            3'd3: return m_route;
            3'd5: return {31'b0, m_mode};
            default: return 0;
        endcase
    endfunction

    function automatic logic exp_out();
        logic [31:0] p;
        p = m_flags & m_route;
        return m_mode ? |(p & ~m_last_pend) : |p;
    endfunction

    task automatic compare_model();
        checks++;
        if (irq_out !== exp_out() || bus_rdata !== exp_rd()) begin
            errors++;
            $display("FAIL %s model: out=%0b rd=%h expected out=%0b rd=%h",
                     cur, irq_out, bus_rdata, exp_out(), exp_rd());
        end
    endtask

    // One clock; compare with the model away from the edge.
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        compare_model();
    endtask

    task automatic idle();
        bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        cyc();
        idle();
    endtask

    task automatic chk_rd(input logic [2:0] a, input logic [31:0] e, input string tag);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1;
        checks++;
        if (bus_rdata !== e) begin
            errors++;
            $display("FAIL %s read idx %0d: actual %h expected %h", tag, a, bus_rdata, e);
        end
        idle();
    endtask

    task automatic chk_out(input logic e, input string tag);
        checks++;
        if (irq_out !== e) begin
            errors++;
            $display("FAIL %s irq_out: actual %0b expected %0b", tag, irq_out, e);
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        for (int a = 0; a < 8; a++) chk_rd(3'(a), 0, "R1");
        chk_out(0, "R1");

        // R2, R11: map, read-only flags, write-only clear, upper bits zero
        cur = "R2";
        wr(3'd0, 32'hFFFF_FFFF);
        chk_rd(3'd0, CHM, "R11");
        wr(3'd2, 32'hFFFF_FFFF);
        chk_rd(3'd2, 0, "R2");
        wr(3'd4, 32'hFFFF_FFFF);
        chk_rd(3'd4, 0, "R2");
        wr(3'd7, 32'hFFFF_FFFF);
        chk_rd(3'd7, 0, "R2");
        wr(3'd5, 32'h3);
        chk_rd(3'd5, 1, "R2");
        wr(3'd5, 0);
        wr(3'd1, 32'hFFFF_FFF7);          // line 3 level, others edge
        chk_rd(3'd1, CHM & 32'hFFFF_FFF7, "R11");

        // R4: edge trigger, held input does not re-set after clear
        cur = "R4";
        irq_in[0] = 1; cyc();
        chk_rd(3'd2, 32'h1, "R4");
        wr(3'd4, 32'h1); cyc();
        chk_rd(3'd2, 0, "R4");
        irq_in[0] = 0; cyc();

        // R5: level trigger re-sets while input high
        cur = "R5";
        irq_in[3] = 1; cyc();
        chk_rd(3'd2, 32'h8, "R5");
        wr(3'd4, 32'h8);
        chk_rd(3'd2, 32'h8, "R5");
        irq_in[3] = 0; cyc();
        wr(3'd4, 32'h8);
        chk_rd(3'd2, 0, "R5");

        // R7: clear and new edge on the same line in one cycle
        cur = "R7";
        irq_in[1] = 1;
        wr(3'd4, 32'h2);
        chk_rd(3'd2, 32'h2, "R7");
        irq_in[1] = 0;
        wr(3'd4, 32'h2);
        chk_rd(3'd2, 0, "R7");

        // R3: gated line captures nothing
        cur = "R3";
        wr(3'd0, CHM & ~32'h20);
        irq_in[5] = 1; cyc(); irq_in[5] = 0; cyc();
        chk_rd(3'd2, 0, "R3");
        wr(3'd0, CHM);
        irq_in[5] = 1; cyc(); irq_in[5] = 0; cyc();
        chk_rd(3'd2, 32'h20, "R3");
        wr(3'd4, 32'h20);

        // R6: clear only selected bits
        cur = "R6";
        irq_in[2:0] = 3'b111; cyc(); irq_in[2:0] = 0; cyc();
        chk_rd(3'd2, 32'h7, "R6");
        wr(3'd4, 32'h2);
        chk_rd(3'd2, 32'h5, "R6");

        // R8, R9: routing gates output only
        cur = "R8";
        chk_out(0, "R8");
        chk_rd(3'd2, 32'h5, "R8");
        cur = "R9";
        wr(3'd3, 32'h1);
        chk_out(1, "R9");
        wr(3'd4, 32'h1);
        chk_out(0, "R9");
        wr(3'd4, 32'h4);

        // R10: pulse output, one cycle per newly set routed flag
        cur = "R10";
        wr(3'd5, 1);
        wr(3'd3, 32'hFFFF_FFFF);
        chk_out(0, "R10");
        irq_in[4] = 1; cyc();
        chk_out(1, "R10");
        irq_in[4] = 0; cyc();
        chk_out(0, "R10");
        cyc();
        chk_out(0, "R10");
        chk_rd(3'd2, 32'h10, "R10");
        irq_in[6] = 1; cyc(); irq_in[6] = 0;
        chk_out(1, "R10");
        cyc();
        chk_out(0, "R10");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule